// File: doc/BRIEF.md
# Interval Timer with Programmable Limit

A peripheral timer built on a 32-bit up-counter that starts at zero and climbs toward a limit held in a register. Software reaches it through a 16-bit register port. Both the 32-bit limit and the live count therefore appear as low and high halves at separate offsets. The timer has two run modes. In periodic mode the counter wraps to zero after it reaches the limit and keeps going. In one-shot mode it halts at the limit and clears its own trigger bit.

On every limit match the block can emit a one-cycle interrupt pulse, gated by an enable bit. A read of the low count half latches the upper half into a shadow register. The following high-half read then pairs with the low half, even when the count carries between the two reads. Software starts the timer with a read-modify-write of the control word and stops it by writing zero.

Top module: `interval_timer`

## Requirements
- R1: After reset the control word, both limit halves and both count halves all read 0, and `irq_o` is low.
- R2: The control word is at offset 0x00. Bit 0 is periodic run, bit 1 is one-shot trigger and bit 8 is interrupt enable. All other bits read as 0. Read data appears on `rdata_o` in the cycle after `rd_en_i` and holds until the next read.
- R3: The limit is written and read back as two halves: bits 15:0 at offset 0x08 and bits 31:16 at offset 0x0C.
- R4: The count is read at offset 0x10 (bits 15:0) and offset 0x14 (bits 31:16). A read of 0x10 copies count bits 31:16 into a shadow register, and a read of 0x14 returns that shadow.
- R5: A control write that starts the timer puts the counter at 0 on that edge. The counter then advances by one on each later edge while running.
- R6: In periodic mode, on the edge after the counter equals the limit, the counter returns to 0. The cycle length is limit+1.
- R7: In one-shot mode (bit 1 set, bit 0 clear), once the counter equals the limit it holds that value and bit 1 clears itself.
- R8: `irq_o` goes high for exactly one cycle, on the edge after a running counter equals the limit, and only when bit 8 is set.
- R9: A control write with bits 1:0 both zero stops the timer and clears the count. A write that sets a run bit that was clear restarts from 0. A write that leaves the run bits as they were lets the count continue.
- R10: With bits 0 and 1 both set, the timer behaves periodically and bit 1 is not cleared.
- R11: Reads of any offset other than 0x00, 0x08, 0x0C, 0x10 and 0x14 return 0. Writes to unmapped offsets and to the count offsets change nothing.
- R12: With the limit at 0 in periodic mode with the interrupt enabled, `irq_o` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The hardest case to reach from the ports is a carry out of the low count half that falls between a low-half read and the matching high-half read. Only in that case does the shadow register return a value different from the live upper half. The stimulus sets a limit above 0x1_0000 and runs periodically for about 65.5k cycles. It then reads the low half just below the carry, waits past the carry, and reads the high half. The expected result is 0 from the shadow, followed by 1 on a fresh pair of reads. The read-modify-write that changes only the interrupt enable mid-run is the other subtle case. It must leave the count running, and that is visible only through the interrupt timing the reference model predicts.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int OFS_CTRL     = 'h00;
  localparam int OFS_LIM_BASE = 'h08;
  localparam int OFS_CNT_BASE = 'h10;
  localparam int OFS_STRIDE   = 4;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_ONE_BIT = 1;
  localparam int CTRL_IEN_BIT = 8;

  typedef struct packed {
    logic run;
    logic one;
    logic ien;
  } ctrl_t;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              done_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic              restart_o,
  output logic [BUS_W-1:0]  rdata_o
);
  localparam int NUM_HALF = CNT_W / BUS_W;
  localparam int SH_W     = CNT_W - BUS_W;

  ctrl_t              ctrl_q;
  logic [CNT_W-1:0]   limit_q;
  logic [SH_W-1:0]    shadow_q;
  logic [BUS_W-1:0]   rdata_q;
  logic [BUS_W-1:0]   rd_val;
  logic               rd_hit;
  logic               ctrl_wr;
  logic               cnt_lo_rd;
  logic [1:0]         new_runs;
  logic [1:0]         old_runs;
  logic [CNT_W-1:0]   cnt_view;

  assign ctrl_wr   = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign cnt_lo_rd = rd_en_i && (addr_i == ADDR_W'(OFS_CNT_BASE));
  assign new_runs  = {wdata_i[CTRL_ONE_BIT], wdata_i[CTRL_RUN_BIT]};
  assign old_runs  = {ctrl_q.one, ctrl_q.run};
  // stop, or a run bit rising, puts the counter back to zero
  assign restart_o = ctrl_wr && ((new_runs == 2'b00) || ((new_runs & ~old_runs) != 2'b00));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.run <= wdata_i[CTRL_RUN_BIT];
      ctrl_q.one <= wdata_i[CTRL_ONE_BIT];
      ctrl_q.ien <= wdata_i[CTRL_IEN_BIT];
    end else if (done_i) begin
      ctrl_q.one <= 1'b0;
    end
  end

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_lim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        limit_q[h*BUS_W +: BUS_W] <= '0;
      end else if (wr_en_i && (addr_i == ADDR_W'(OFS_LIM_BASE + OFS_STRIDE*h))) begin
        limit_q[h*BUS_W +: BUS_W] <= wdata_i;
      end
    end
  end

  assign cnt_view = {shadow_q, count_i[BUS_W-1:0]};

  always_comb begin
    rd_val = '0;
    rd_hit = 1'b0;
    if (addr_i == ADDR_W'(OFS_CTRL)) begin
      rd_hit               = 1'b1;
      rd_val[CTRL_RUN_BIT] = ctrl_q.run;
      rd_val[CTRL_ONE_BIT] = ctrl_q.one;
      rd_val[CTRL_IEN_BIT] = ctrl_q.ien;
    end
    for (int h = 0; h < NUM_HALF; h++) begin
      if (addr_i == ADDR_W'(OFS_LIM_BASE + OFS_STRIDE*h)) begin
        rd_hit = 1'b1;
        rd_val = limit_q[h*BUS_W +: BUS_W];
      end
      if (addr_i == ADDR_W'(OFS_CNT_BASE + OFS_STRIDE*h)) begin
        rd_hit = 1'b1;
        rd_val = cnt_view[h*BUS_W +: BUS_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      shadow_q <= '0;
    end else begin
      if (rd_en_i)   rdata_q  <= rd_val;
      if (cnt_lo_rd) shadow_q <= count_i[CNT_W-1:BUS_W];
    end
  end

  assign ctrl_o  = ctrl_q;
  assign limit_o = limit_q;
  assign rdata_o = rdata_q;

  AST_TRIG_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !ctrl_wr |=> !ctrl_q.one); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !rd_hit |=> rdata_q == '0); // R11
  AST_SHADOW_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_lo_rd |=> shadow_q == $past(count_i[CNT_W-1:BUS_W])); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_q)); // R2
endmodule

// File: rtl/timer_core.sv
module timer_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             one_i,
  input  logic             ien_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] count_q;
  logic             irq_q;
  logic             active;
  logic             hit;

  assign active = run_i || one_i;
  assign hit    = active && (count_q == limit_i);
  assign done_o = hit && !run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (restart_i) begin
      count_q <= '0;
    end else if (hit) begin
      if (run_i) count_q <= '0;   // periodic wrap; one-shot holds
    end else if (active) begin
      count_q <= count_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= hit && ien_i;
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(ien_i && active)); // R8
  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && !hit && !restart_i |=> count_q == $past(count_q) + 1'b1); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && run_i && !restart_i |=> count_q == '0); // R6
  AST_ONESHOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !run_i && !restart_i |=> $stable(count_q)); // R7
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> count_q == '0); // R9
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * BUS_W;

  ctrl_t            ctrl;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] count;
  logic             restart;
  logic             done;

  timer_regs #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .count_i   (count),
    .done_i    (done),
    .ctrl_o    (ctrl),
    .limit_o   (limit),
    .restart_o (restart),
    .rdata_o   (rdata_o)
  );

  timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ctrl.run),
    .one_i     (ctrl.one),
    .ien_i     (ctrl.ien),
    .limit_i   (limit),
    .restart_i (restart),
    .count_o   (count),
    .done_o    (done),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done_flag = 1'b0;

  always #5 clk_i = ~clk_i;

  interval_timer u_interval_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // behavioural reference model
  bit          m_run, m_one, m_ien, m_irq, m_act, m_hit;
  logic [31:0] m_lim, m_cnt;
  logic [15:0] m_sh, m_rd;
  logic [1:0]  m_new, m_old;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_one = 0; m_ien = 0; m_irq = 0;
      m_lim = 0; m_cnt = 0; m_sh = 0; m_rd = 0;
    end else begin
      m_old = {m_one, m_run};
      m_act = m_run || m_one;
      m_hit = m_act && (m_cnt == m_lim);
      m_irq = m_hit && m_ien;
      if (rd_en_i) begin
        case (addr_i)
          5'h00: m_rd = {7'd0, m_ien, 6'd0, m_one, m_run};
          5'h08: m_rd = m_lim[15:0];
          5'h0C: m_rd = m_lim[31:16];
          5'h10: begin m_rd = m_cnt[15:0]; m_sh = m_cnt[31:16]; end
          5'h14: m_rd = m_sh;
          default: m_rd = 16'h0;
        endcase
      end
      if (m_hit) begin
        if (m_run) m_cnt = 0; else m_one = 0;
      end else if (m_act) m_cnt = m_cnt + 1;
      if (wr_en_i) begin
        case (addr_i)
          5'h00: begin
            m_new = wdata_i[1:0];
            if (m_new == 2'b00 || (m_new & ~m_old) != 2'b00) m_cnt = 0;
            m_run = wdata_i[0]; m_one = wdata_i[1]; m_ien = wdata_i[8];
          end
          5'h08: m_lim[15:0]  = wdata_i;
          5'h0C: m_lim[31:16] = wdata_i;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done_flag) begin
      check(irq_o === m_irq, cur_req, "irq_o vs model", {31'd0, irq_o}, {31'd0, m_irq});
      check(rdata_o === m_rd, cur_req, "rdata_o vs model", {16'd0, rdata_o}, {16'd0, m_rd});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic count_irq(input int n, output int pulses, output int longest);
    int run_len;
    pulses = 0; longest = 0; run_len = 0;
    for (int i = 0; i < n; i++) begin
      if (irq_o) begin
        run_len++;
        if (run_len == 1) pulses++;
        if (run_len > longest) longest = run_len;
      end else run_len = 0;
      @(negedge clk_i);
    end
  endtask

  task automatic summary;
    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] v;
    int p, l;
    idle(2);
    rst_ni = 1'b1;
    idle(1);

    cur_req = "R1";
    check(irq_o === 1'b0, "R1", "irq after reset", {31'd0, irq_o}, 0);
    rd(5'h00, v); check(v == 0, "R1", "ctrl after reset", v, 0);
    rd(5'h08, v); check(v == 0, "R1", "limit lo after reset", v, 0);
    rd(5'h0C, v); check(v == 0, "R1", "limit hi after reset", v, 0);
    rd(5'h10, v); check(v == 0, "R1", "count lo after reset", v, 0);
    rd(5'h14, v); check(v == 0, "R1", "count hi after reset", v, 0);

    cur_req = "R3";
    wr(5'h08, 16'hABCD); wr(5'h0C, 16'h1234);
    rd(5'h08, v); check(v == 16'hABCD, "R3", "limit lo readback", v, 16'hABCD);
    rd(5'h0C, v); check(v == 16'h1234, "R3", "limit hi readback", v, 16'h1234);

    cur_req = "R2";
    wr(5'h00, 16'h00FC);
    rd(5'h00, v); check(v == 16'h0000, "R2", "reserved ctrl bits", v, 0);
    wr(5'h00, 16'hFEFF);
    rd(5'h00, v); check(v == 16'h0003, "R2", "ctrl run bits only", v, 16'h0003);
    idle(3);
    cur_req = "R9";
    wr(5'h00, 16'h0000);
    rd(5'h10, v); check(v == 0, "R9", "count lo after stop", v, 0);
    rd(5'h14, v); check(v == 0, "R9", "count hi after stop", v, 0);

    cur_req = "R5";
    wr(5'h08, 16'd9); wr(5'h0C, 16'd0);
    wr(5'h00, 16'h0001);
    rd(5'h10, v); check(v == 0, "R5", "count right after start", v, 0);
    rd(5'h10, v); check(v == 1, "R5", "count one edge later", v, 1);
    rd(5'h10, v); check(v == 2, "R5", "count two edges later", v, 2);

    cur_req = "R6";
    wr(5'h00, 16'h0000);
    wr(5'h00, 16'h0101);
    idle(5);
    count_irq(20, p, l);
    check(p == 2, "R6", "pulses in 20 cycles at limit 9", p, 2);
    check(l == 1, "R8", "pulse width", l, 1);

    cur_req = "R9";
    wr(5'h00, 16'h0001);
    count_irq(25, p, l);
    check(p == 0, "R8", "no pulse with enable clear", p, 0);
    wr(5'h00, 16'h0101);
    idle(30);
    wr(5'h00, 16'h0000);
    rd(5'h10, v); check(v == 0, "R9", "count after stop write", v, 0);
    idle(3);
    rd(5'h10, v); check(v == 0, "R9", "count stays stopped", v, 0);

    cur_req = "R7";
    wr(5'h00, 16'h0102);
    count_irq(25, p, l);
    check(p == 1, "R7", "one-shot pulse count", p, 1);
    rd(5'h00, v); check(v == 16'h0100, "R7", "trigger self-cleared", v, 16'h0100);
    rd(5'h10, v); check(v == 9, "R7", "count holds at limit", v, 9);

    cur_req = "R10";
    wr(5'h00, 16'h0000);
    wr(5'h00, 16'h0103);
    count_irq(25, p, l);
    check(p >= 2, "R10", "both bits runs periodically", p, 2);
    rd(5'h00, v); check(v == 16'h0103, "R10", "trigger kept when periodic", v, 16'h0103);

    cur_req = "R12";
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'd0);
    wr(5'h00, 16'h0101);
    idle(2);
    count_irq(10, p, l);
    check(l == 10, "R12", "irq every cycle at limit 0", l, 10);

    cur_req = "R11";
    wr(5'h00, 16'h0000);
    wr(5'h04, 16'hFFFF); wr(5'h18, 16'hFFFF);
    wr(5'h10, 16'h5555); wr(5'h14, 16'h5555);
    rd(5'h04, v); check(v == 0, "R11", "unmapped 0x04", v, 0);
    rd(5'h18, v); check(v == 0, "R11", "unmapped 0x18", v, 0);
    rd(5'h02, v); check(v == 0, "R11", "unmapped 0x02", v, 0);
    rd(5'h10, v); check(v == 0, "R11", "count lo not writable", v, 0);
    rd(5'h14, v); check(v == 0, "R11", "count hi not writable", v, 0);
    rd(5'h08, v); check(v == 0, "R11", "limit untouched", v, 0);
    rd(5'h00, v); check(v == 0, "R11", "ctrl untouched", v, 0);

    cur_req = "R4";
    wr(5'h0C, 16'd2);
    wr(5'h00, 16'h0001);
    idle(65520);
    rd(5'h10, v); check(v > 16'hFF00, "R4", "low half near carry", v, 16'hFF00);
    idle(40);
    rd(5'h14, v); check(v == 0, "R4", "high half from shadow", v, 0);
    rd(5'h10, v);
    rd(5'h14, v); check(v == 1, "R4", "high half after carry", v, 1);
    wr(5'h00, 16'h0000);
    idle(2);

    summary();
  end
endmodule